// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and a single-port main memory. Stores leaving the cache are queued in a small FIFO and retired to memory one at a time, oldest first, whenever the memory port is free and no read miss is waiting. A read miss is given the memory port ahead of any queued store. This shortens the miss penalty, but it opens a hazard. A store to the same address may still be queued, for example after a conflicting miss evicted the line that store belonged to. Reading memory at that point would return stale data.

A `mode` input chooses how that hazard is handled. In drain mode (`mode`=0), a read miss waits until every queued store has reached memory and the port is idle, and only then reads memory. In compare mode (`mode`=1), the miss address is checked against every queued entry. On a hit, the youngest matching entry's data is returned directly, without touching memory. On a miss, the read goes to memory ahead of the queued stores. The memory port uses a fixed latency `MEM_LAT`, and only one transaction is in flight at a time.

Top module: `wbrb_top`

## Requirements
- R1: In compare mode, when a read miss that hits no queued entry is waiting and the port is idle, the read is issued (`mem_req`=1, `mem_we`=0) even if stores are still queued.
- R2: In compare mode, a read miss whose address matches a queued entry gets `rd_resp_valid`=1 in the cycle after `rd_req` is first seen, with that entry's data, and no memory read is issued for it.
- R3: When several queued entries match the read address, the data comes from the most recently accepted one.
- R4: In drain mode, a read miss is issued to memory only when `buf_empty`=1, and it returns the value written by the last queued store to that address.
- R5: A read issued to memory returns `mem_rdata` as sampled `MEM_LAT` cycles after the issue cycle, with `rd_resp_valid` high `MEM_LAT`+1 cycles after the issue cycle.
- R6: Queued stores reach memory in acceptance order, each exactly once. A new request is never issued in the cycle after a request.
- R7: With 4 entries queued, `buf_full`=1 and `st_ready`=0. A store held during that time is accepted exactly once, when space frees.
- R8: After reset, `buf_empty`=1, `buf_full`=0, `st_ready`=1, `mem_req`=0 and `rd_resp_valid`=0.
- R9: With no read pending and the port idle, a non-empty buffer issues its oldest store (`mem_req`=1, `mem_we`=1) in the cycle right after that store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0: drain before read, 1: compare and forward |
| st_valid | input | 1 | Store offered by the cache |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store accepted this cycle if valid |
| buf_full | output | 1 | All entries occupied |
| buf_empty | output | 1 | No entries occupied |
| rd_req | input | 1 | Read miss pending; held until response |
| rd_addr | input | ADDR_W | Read miss address |
| rd_resp_valid | output | 1 | One-cycle read response strobe |
| rd_resp_data | output | DATA_W | Read response data |
| mem_req | output | 1 | Memory request, one cycle per transaction |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid MEM_LAT cycles after a read request |

## Verification
The bench targets the stale-read hazard in both modes.

- In compare mode, a read to an address with a queued store must be answered from the buffer. A design that skipped the compare would return the old memory word.
- With two queued stores to the same address, the bench expects the second value. A design that chose the oldest match would return the first.
- In drain mode, the read issue is logged together with the buffer state at that moment. A design that let the read bypass the queue would be caught reading while stores were still queued.
- The bench also records the exact order of memory writes across a full-buffer stall and the latency of a bypassing read. A design that lost or duplicated the stalled store, let the read wait behind the queue, or mistimed the response would show up there.

// File: rtl/wbrb_pkg.sv
package wbrb_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } mem_op_e;

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/wbrb_fifo.sv
module wbrb_fifo
    import wbrb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = ptr_width(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  wb_entry_t       push_entry,
    input  logic            pop,
    output wb_entry_t       slots [DEPTH],
    output logic [PW-1:0]   head_ptr,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            empty
);
    wb_entry_t     store_q [DEPTH];
    logic [PW-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            head_ptr <= '0;
            count    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  head_ptr <= head_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) store_q[wr_ptr] <= push_entry;
    end

    assign slots = store_q;
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/wbrb_match.sv
module wbrb_match
    import wbrb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = ptr_width(DEPTH),
    localparam int CW = PW + 1
) (
    input  wb_entry_t          slots [DEPTH],
    input  logic [PW-1:0]      head_ptr,
    input  logic [CW-1:0]      count,
    input  logic [ADDR_W-1:0]  lookup_addr,
    output logic               hit,
    output logic [DATA_W-1:0]  hit_data
);
    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr + PW'(k);
            if ((CW'(k) < count) && (slots[idx].addr == lookup_addr)) begin
                hit      = 1'b1;
                hit_data = slots[idx].data;
            end
        end
    end
endmodule

// File: rtl/wbrb_port_arb.sv
module wbrb_port_arb
    import wbrb_pkg::*;
#(
    parameter int MEM_LAT = 4,
    localparam int LW = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_go,
    input  logic wr_go,
    output logic grant_rd,
    output logic grant_wr,
    output logic rd_busy,
    output logic rd_capture
);
    arb_state_e    state;
    mem_op_e       op;
    logic [LW-1:0] cnt;
    logic          idle;

    assign idle       = (state == ARB_IDLE);
    assign grant_rd   = idle && rd_go;
    assign grant_wr   = idle && !rd_go && wr_go;
    assign rd_busy    = (state == ARB_BUSY) && (op == OP_READ);
    assign rd_capture = rd_busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
            op    <= OP_WRITE;
            cnt   <= '0;
        end else if (idle) begin
            if (grant_rd || grant_wr) begin
                state <= ARB_BUSY;
                op    <= grant_rd ? OP_READ : OP_WRITE;
                cnt   <= LW'(MEM_LAT - 1);
            end
        end else if (cnt == '0) begin
            state <= ARB_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wbrb_top.sv
module wbrb_top
    import wbrb_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int MEM_LAT = 4,
    localparam int PW = ptr_width(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    output logic              buf_full,
    output logic              buf_empty,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    wb_entry_t         slots [DEPTH];
    wb_entry_t         head_entry;
    logic [PW-1:0]     head_ptr;
    logic [CW-1:0]     count;
    logic              push, pop;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              rd_pend, fwd, rd_go;
    logic              grant_rd, grant_wr, rd_busy, rd_capture;

    assign st_ready = !buf_full;
    assign push     = st_valid && st_ready;
    assign pop      = grant_wr;

    wbrb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .push_entry('{addr: st_addr, data: st_data}), .pop(pop),
        .slots(slots), .head_ptr(head_ptr), .count(count),
        .full(buf_full), .empty(buf_empty)
    );

    wbrb_match #(.DEPTH(DEPTH)) u_match (
        .slots(slots), .head_ptr(head_ptr), .count(count),
        .lookup_addr(rd_addr), .hit(lk_hit), .hit_data(lk_data)
    );

    // A read is live until answered and not already in flight.
    assign rd_pend = rd_req && !rd_resp_valid && !rd_busy;
    assign fwd     = rd_pend && mode && lk_hit;
    assign rd_go   = rd_pend && (mode ? !lk_hit : buf_empty);

    wbrb_port_arb #(.MEM_LAT(MEM_LAT)) u_arb (
        .clk(clk), .rst(rst),
        .rd_go(rd_go), .wr_go(!buf_empty),
        .grant_rd(grant_rd), .grant_wr(grant_wr),
        .rd_busy(rd_busy), .rd_capture(rd_capture)
    );

    assign head_entry = slots[head_ptr];
    assign mem_req    = grant_rd || grant_wr;
    assign mem_we     = grant_wr;
    assign mem_addr   = grant_wr ? head_entry.addr : rd_addr;
    assign mem_wdata  = head_entry.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_resp_valid <= 1'b0;
            rd_resp_data  <= '0;
        end else begin
            rd_resp_valid <= fwd || rd_capture;
            if (fwd)             rd_resp_data <= lk_data;
            else if (rd_capture) rd_resp_data <= mem_rdata;
        end
    end
endmodule

// File: rtl/wbrb_checker.sv
module wbrb_checker (
    input logic clk,
    input logic rst,
    input logic mode,
    input logic st_valid,
    input logic st_ready,
    input logic buf_full,
    input logic buf_empty,
    input logic rd_req,
    input logic rd_resp_valid,
    input logic mem_req,
    input logic mem_we,
    input logic hit,
    input logic rd_busy
);
    AST_READ_BEATS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !(rd_req && !rd_resp_valid && !rd_busy && mode && !hit)); // R1

    AST_FWD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_resp_valid && !rd_busy && mode && hit) |=> rd_resp_valid); // R2

    AST_FWD_NO_MEM_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_resp_valid && !rd_busy && mode && hit) |-> !(mem_req && !mem_we)); // R2

    AST_DRAIN_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !mode) |-> buf_empty); // R4

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R6

    AST_FULL_FROM_PUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> $past(st_valid && st_ready)); // R7

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> !mem_req); // R6
endmodule

bind wbrb_top wbrb_checker u_chk (
    .clk(clk), .rst(rst), .mode(mode),
    .st_valid(st_valid), .st_ready(st_ready),
    .buf_full(buf_full), .buf_empty(buf_empty),
    .rd_req(rd_req), .rd_resp_valid(rd_resp_valid),
    .mem_req(mem_req), .mem_we(mem_we),
    .hit(lk_hit), .rd_busy(rd_busy)
);

// File: tb/test_wbrb_top.sv
module test_wbrb_top;
    import wbrb_pkg::*;

    localparam int LAT = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode = 1'b1;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic              st_ready, buf_full, buf_empty;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_resp_valid;
    logic [DATA_W-1:0] rd_resp_data;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    wbrb_top #(.DEPTH(4), .MEM_LAT(LAT)) i_wbrb_top (
        .clk(clk), .rst(rst), .mode(mode),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .buf_full(buf_full), .buf_empty(buf_empty),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model and transaction log, all sampled at the falling edge.
    logic [DATA_W-1:0] mem [256];
    logic [7:0]        rd_idx = '0;
    logic [7:0]        wlog [64];
    int wcnt = 0, rcnt = 0, cyc = 0;
    int rd_issue_cyc = 0, resp_cyc = 0;
    logic empty_at_rd = 1'b0;

    assign mem_rdata = mem[rd_idx];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
        end else begin
            if (mem_req && mem_we) begin
                mem[mem_addr[7:0]] = mem_wdata;
                wlog[wcnt[5:0]] = mem_addr[7:0];
                wcnt = wcnt + 1;
            end else if (mem_req) begin
                rd_idx = mem_addr[7:0];
                rcnt = rcnt + 1;
                rd_issue_cyc = cyc;
                empty_at_rd = buf_empty;
            end
            if (rd_resp_valid) resp_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_store(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = ADDR_W'(a);
        st_data  = d;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output int waits);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = ADDR_W'(a);
        waits = 0;
        do begin
            @(negedge clk);
            #1;
            waits++;
        end while (!rd_resp_valid && waits < 1000);
        d = rd_resp_data;
        rd_req = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!buf_empty) @(negedge clk);
        repeat (LAT + 3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(buf_empty == 1'b1, "R8 buf_empty", buf_empty, 1);
        check(buf_full == 1'b0,  "R8 buf_full", buf_full, 0);
        check(st_ready == 1'b1,  "R8 st_ready", st_ready, 1);
        check(mem_req == 1'b0,   "R8 mem_req", mem_req, 0);
        check(rd_resp_valid == 1'b0, "R8 rd_resp_valid", rd_resp_valid, 0);
    endtask

    task automatic t_drain_start();
        mode = 1'b1;
        push_store(8'h10, 32'h1111_0010);
        @(negedge clk);
        #1;
        check(mem_req && mem_we, "R9 drain issue", {mem_req, mem_we}, 2'b11);
        check(mem_addr[7:0] == 8'h10, "R9 drain addr", mem_addr, 8'h10);
        wait_idle();
        check(mem[8'h10] == 32'h1111_0010, "R9 memory written", mem[8'h10], 32'h1111_0010);
    endtask

    task automatic t_forward();
        logic [31:0] d;
        int w, r0;
        mode = 1'b1;
        push_store(8'h20, 32'h0000_2020);
        push_store(8'h21, 32'h0000_0055);
        r0 = rcnt;
        do_read(8'h21, d, w);
        check(d == 32'h0000_0055, "R2 forwarded data", d, 32'h55);
        check(w == 1, "R2 forward latency", w, 1);
        wait_idle();
        check(rcnt == r0, "R2 no memory read", rcnt - r0, 0);
    endtask

    task automatic t_youngest();
        logic [31:0] d;
        int w;
        mode = 1'b1;
        push_store(8'h30, 32'h0000_3030);
        push_store(8'h31, 32'h0000_0011);
        push_store(8'h31, 32'h0000_0022);
        do_read(8'h31, d, w);
        check(d == 32'h0000_0022, "R3 youngest match", d, 32'h22);
        wait_idle();
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        int w, w0;
        mode = 1'b1;
        w0 = wcnt;
        push_store(8'h41, 32'h0000_0041);
        push_store(8'h42, 32'h0000_0042);
        push_store(8'h43, 32'h0000_0043);
        do_read(8'h44, d, w);
        check(empty_at_rd == 1'b0, "R1 read ahead of queued stores", empty_at_rd, 0);
        check(d == 32'hA000_0044, "R5 memory data", d, 32'hA000_0044);
        check(resp_cyc - rd_issue_cyc == LAT + 1, "R5 response latency",
              resp_cyc - rd_issue_cyc, LAT + 1);
        wait_idle();
        check(wcnt - w0 == 3, "R6 write count", wcnt - w0, 3);
        for (int i = 0; i < 3; i++)
            check(wlog[6'(w0 + i)] == 8'(8'h41 + i), "R6 write order",
                  wlog[6'(w0 + i)], 8'h41 + i);
    endtask

    task automatic t_drain_mode();
        logic [31:0] d;
        int w;
        mode = 1'b0;
        push_store(8'h50, 32'h0000_5050);
        push_store(8'h51, 32'h0000_0077);
        do_read(8'h51, d, w);
        check(d == 32'h0000_0077, "R4 drained data", d, 32'h77);
        check(empty_at_rd == 1'b1, "R4 read after empty", empty_at_rd, 1);
        wait_idle();
        mode = 1'b1;
    endtask

    task automatic t_full();
        int w0;
        mode = 1'b1;
        w0 = wcnt;
        for (int i = 0; i < 5; i++) push_store(8'(8'h60 + i), 32'(32'h600 + i));
        @(negedge clk);
        #1;
        check(buf_full == 1'b1, "R7 buf_full", buf_full, 1);
        check(st_ready == 1'b0, "R7 st_ready stall", st_ready, 0);
        push_store(8'h65, 32'h0000_0605);
        wait_idle();
        check(wcnt - w0 == 6, "R7 stalled store once", wcnt - w0, 6);
        for (int i = 0; i < 6; i++)
            check(wlog[6'(w0 + i)] == 8'(8'h60 + i), "R6 order across stall",
                  wlog[6'(w0 + i)], 8'h60 + i);
        check(mem[8'h65] == 32'h0000_0605, "R7 stalled data", mem[8'h65], 32'h605);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_drain_start();
        t_forward();
        t_youngest();
        t_bypass();
        t_drain_mode();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule